// File: doc/BRIEF.md
# SD card clock generator

This block derives the card clock for an SD/SDIO host from one of two source clocks: a fixed 200 MHz bus clock or a PLL clock. A single 32-bit control word, written on a register clock with a one-cycle strobe, carries three fields. One field picks the source. One field gates the output. A 3-bit code sets the divide ratio. An 8-bit silicon revision input changes what the highest code means. On early silicon it is one more even ratio. On later silicon it is a bypass, so the bus clock alone yields a 200 MHz card clock.

Changing the source, the gate or the ratio while the output runs never produces a runt pulse. The source multiplexer stops the old clock in its low phase before it starts the new one. The divider takes new settings only at the end of an output low phase, so a new high phase always has the new full length. The control fields cross into the divided-clock domain through a synchronizer. Software is expected to hold a written word for at least a few source cycles before it writes the next one.

Top module: `sdclk_gen`

## Requirements
- R1: After a synchronous active-low reset the control word is zero: bus clock selected, gate off, code 0. The output stays low with no edges.
- R2: While control bit 31 (enable) is 0, the output is held low. Turning the gate on or off never produces a pulse shorter than the active half period.
- R3: Codes 0 to 6 in control bits 30:28 divide the selected source by 2*(code+1). The output has a 50% duty cycle: high and low each last code+1 source periods.
- R4: When the revision input, read as an unsigned number, is below 2, code 7 divides by 16 (high and low 8 source periods each).
- R5: When the revision input is 2 or more, code 7 passes the selected source through undivided. With the bus clock this gives a 200 MHz output.
- R6: Control bit 8 selects the source: 0 selects the bus clock and 1 selects the PLL clock.
- R7: Source switching is glitch-free. The two source enables are never on together, and no output pulse is shorter than the shortest half period of the old and new settings.
- R8: A new divide code takes effect at the end of an output low phase. No pulse around the change is shorter than the smaller of the old and new half periods, and the ratio then matches the new code.
- R9: The control word is loaded from the write-data input on a register clock edge where the write strobe is 1. When the strobe is 0 the output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| reg_clk | input | 1 | Register clock for the control word |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of every clock |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word: bit 31 enable, bits 30:28 divide code, bit 8 source select |
| rev_id | input | 8 | Silicon revision value, unsigned |
| bus_clk | input | 1 | Fixed 200 MHz bus clock source |
| pll_clk | input | 1 | PLL clock source |
| sd_clk | output | 1 | Divided, gated card clock |

## Verification
On every cycle the assertions check that the two source enables are never on together and that the divide counter stays below the active half count. They also check that the divided signal falls after exactly one half count and stays low while the gate is off or bypass is active, and that a write loads the word. Only the bench scenarios show the actual ratios per code, source and revision. They also show the minimum pulse width measured at the output across source, gate, code and bypass changes, since those depend on the timing of both source clocks.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
// sdclk_pkg: shared widths and the decoded divider setting passed between
// the register domain and the divided-clock domain.
package sdclk_pkg;
    localparam int CODE_W = 3;
    localparam int HALF_W = CODE_W + 1;

    // Decoded divider setting: gate, bypass flag, half-period in source cycles.
    typedef struct packed {
        logic              gate;
        logic              byp;
        logic [HALF_W-1:0] half;
    } div_cfg_t;
endpackage

// File: rtl/sdclk_sync.sv
`timescale 1ns/1ps
// sdclk_sync: plain multi-stage flop synchronizer for a bus of quasi-static
// bits. Assumes the source holds its value for longer than STAGES cycles.
module sdclk_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        // Shift the value one stage further into the clk domain.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[i] <= '0;
            else if (i == 0) stg[i] <= d;
            else stg[i] <= stg[(i == 0) ? 0 : i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sdclk_ctrl.sv
`timescale 1ns/1ps
// sdclk_ctrl: holds the control word in the register domain and decodes it
// into a source select and a divider setting. Assumes the revision input is
// static during operation.
module sdclk_ctrl
    import sdclk_pkg::*;
#(
    parameter int CW         = 32,
    parameter int REV_W      = 8,
    parameter int SEL_BIT    = 8,
    parameter int EN_BIT     = 31,
    parameter int CODE_LSB   = 28,
    parameter int BYPASS_REV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CW-1:0]    wdata,
    input  logic [REV_W-1:0] rev,
    output logic             sel,
    output div_cfg_t         dcfg
);
    localparam logic [CODE_W-1:0] TOP_CODE = '1;

    logic [CW-1:0]     word;
    logic [CODE_W-1:0] code;
    logic              late_rev;

    // Load the control word on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) word <= '0;
        else if (wr) word <= wdata;
    end

    assign code     = word[CODE_LSB +: CODE_W];
    assign late_rev = (rev >= REV_W'(BYPASS_REV));
    assign sel      = word[SEL_BIT];

    // Decode the top code by revision; other codes give half = code + 1.
    always_comb begin
        dcfg.gate = word[EN_BIT];
        dcfg.byp  = (code == TOP_CODE) && late_rev;
        dcfg.half = dcfg.byp ? HALF_W'(1) : (HALF_W'(code) + HALF_W'(1));
    end

    p_write_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (word == $past(wdata)));
endmodule

// File: rtl/sdclk_src_mux.sv
`timescale 1ns/1ps
// sdclk_src_mux: glitch-free two-source clock multiplexer. Each source's
// enable is captured on its rising edge and applied on its falling edge, and
// waits for the other enable to drop. Both sources must run during reset;
// the bus clock is enabled out of reset.
module sdclk_src_mux (
    input  logic rst_n,
    input  logic sel,
    input  logic bus_clk,
    input  logic pll_clk,
    output logic mux_clk
);
    logic bus_req, bus_on;
    logic pll_req, pll_on;

    // Bus side: request when not selected-away and PLL side is off.
    always_ff @(posedge bus_clk) begin
        if (!rst_n) bus_req <= 1'b1;
        else bus_req <= !sel && !pll_on;
    end

    // Bus side: apply the enable while the bus clock is low.
    always_ff @(negedge bus_clk) begin
        if (!rst_n) bus_on <= 1'b1;
        else bus_on <= bus_req;
    end

    // PLL side: request when selected and bus side is off.
    always_ff @(posedge pll_clk) begin
        if (!rst_n) pll_req <= 1'b0;
        else pll_req <= sel && !bus_on;
    end

    // PLL side: apply the enable while the PLL clock is low.
    always_ff @(negedge pll_clk) begin
        if (!rst_n) pll_on <= 1'b0;
        else pll_on <= pll_req;
    end

    assign mux_clk = (bus_clk & bus_on) | (pll_clk & pll_on);

    p_one_source_bus_r7: assert property (@(posedge bus_clk) disable iff (!rst_n)
        !(bus_on && pll_on));
    p_one_source_pll_r7: assert property (@(posedge pll_clk) disable iff (!rst_n)
        !(bus_on && pll_on));
endmodule

// File: rtl/sdclk_divider.sv
`timescale 1ns/1ps
// sdclk_divider: even-ratio divider with gate and bypass, clocked by the
// multiplexed source. New settings are adopted only at the end of a low
// phase of the output; the bypass select changes on the falling source edge.
module sdclk_divider
    import sdclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     rst_n,
    input  logic     mux_clk,
    input  div_cfg_t cfg_in,
    output logic     sd_clk_o
);
    localparam int CFG_W = $bits(div_cfg_t);

    logic [CFG_W-1:0]  s_vec;
    div_cfg_t          s_cfg;
    div_cfg_t          act;
    logic [HALF_W-1:0] cnt;
    logic              div_q;
    logic              bsel;
    logic              at_bound;
    logic              start_low;
    logic              last_cnt;

    sdclk_sync #(.W(CFG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (mux_clk),
        .rst_n(rst_n),
        .d    (cfg_in),
        .q    (s_vec)
    );
    assign s_cfg = div_cfg_t'(s_vec);

    assign last_cnt  = (cnt == act.half - HALF_W'(1));
    assign at_bound  = !div_q && (last_cnt || !act.gate || act.byp);
    assign start_low = act.gate && act.byp;

    // Count half periods; reload settings only at the end of a low phase.
    always_ff @(posedge mux_clk) begin
        if (!rst_n) begin
            act   <= '{gate: 1'b0, byp: 1'b0, half: HALF_W'(1)};
            cnt   <= '0;
            div_q <= 1'b0;
        end else if (at_bound) begin
            act   <= s_cfg;
            cnt   <= '0;
            div_q <= s_cfg.gate && !s_cfg.byp && !start_low;
        end else if (last_cnt) begin
            cnt   <= '0;
            div_q <= 1'b0;
        end else begin
            cnt   <= cnt + HALF_W'(1);
        end
    end

    // Switch between divided and bypass output while the source is low.
    always_ff @(negedge mux_clk) begin
        if (!rst_n) bsel <= 1'b0;
        else bsel <= act.gate && act.byp;
    end

    assign sd_clk_o = bsel ? mux_clk : div_q;

    p_cnt_bound_r3: assert property (@(posedge mux_clk) disable iff (!rst_n)
        act.gate |-> (cnt < act.half));
    p_half_toggle_r3: assert property (@(posedge mux_clk) disable iff (!rst_n)
        (div_q && act.gate && last_cnt) |=> !div_q);
    p_gate_quiet_r2: assert property (@(posedge mux_clk) disable iff (!rst_n)
        !act.gate |-> !div_q);
    p_bypass_quiet_r5: assert property (@(posedge mux_clk) disable iff (!rst_n)
        act.byp |-> !div_q);
endmodule

// File: rtl/sdclk_gen.sv
`timescale 1ns/1ps
// sdclk_gen: SD card clock generator top. Register-domain control word,
// glitch-free source select, then gated even-ratio or bypass divider.
// Assumes rst_n is held for several cycles of every clock.
module sdclk_gen
    import sdclk_pkg::*;
#(
    parameter int CW          = 32,
    parameter int REV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             reg_clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CW-1:0]    cfg_wdata,
    input  logic [REV_W-1:0] rev_id,
    input  logic             bus_clk,
    input  logic             pll_clk,
    output logic             sd_clk
);
    logic     sel;
    div_cfg_t dcfg;
    logic     mux_clk;

    sdclk_ctrl #(.CW(CW), .REV_W(REV_W)) u_ctrl (
        .clk  (reg_clk),
        .rst_n(rst_n),
        .wr   (cfg_wr),
        .wdata(cfg_wdata),
        .rev  (rev_id),
        .sel  (sel),
        .dcfg (dcfg)
    );

    sdclk_src_mux u_mux (
        .rst_n  (rst_n),
        .sel    (sel),
        .bus_clk(bus_clk),
        .pll_clk(pll_clk),
        .mux_clk(mux_clk)
    );

    sdclk_divider #(.SYNC_STAGES(SYNC_STAGES)) u_div (
        .rst_n   (rst_n),
        .mux_clk (mux_clk),
        .cfg_in  (dcfg),
        .sd_clk_o(sd_clk)
    );
endmodule

// File: tb/sdclk_gen_test.sv
`timescale 1ns/1ps
module sdclk_gen_test;
    logic        reg_clk = 1'b0;
    logic        bus_clk = 1'b0;
    logic        pll_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic        cfg_wr  = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  rev_id  = 8'd0;
    logic        sd_clk;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    localparam real BUS_P = 5.0;
    localparam real PLL_P = 7.0;

    always #2.0 reg_clk = ~reg_clk;   // 250 MHz register clock
    always #2.5 bus_clk = ~bus_clk;   // 200 MHz bus clock
    always #3.5 pll_clk = ~pll_clk;   // PLL clock

    sdclk_gen uut (
        .reg_clk  (reg_clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .rev_id   (rev_id),
        .bus_clk  (bus_clk),
        .pll_clk  (pll_clk),
        .sd_clk   (sd_clk)
    );

    // Expected high (= low) time of the output for a setting.
    function automatic real exp_half(input bit sel, input int code, input int rev);
        real p;
        p = sel ? PLL_P : BUS_P;
        if (code == 7 && rev >= 2) return p / 2.0;
        if (code == 7) return 8.0 * p;
        return real'(code + 1) * p;
    endfunction

    task automatic check_real(input string req, input real act, input real exp);
        tests++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            fails++;
            $display("FAIL %s: actual %0.3f expected %0.3f", req, act, exp);
        end
    endtask

    task automatic check_min(input string req, input real act, input real lim);
        tests++;
        if (act < lim - 0.01) begin
            fails++;
            $display("FAIL %s: actual min pulse %0.3f expected >= %0.3f", req, act, lim);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input bit en, input bit sel, input int code, input bit strobe);
        logic [31:0] w;
        w = $urandom;
        w[31] = en;
        w[30:28] = 3'(code);
        w[8] = sel;
        @(negedge reg_clk);
        cfg_wdata = w;
        cfg_wr = strobe;
        @(negedge reg_clk);
        cfg_wr = 1'b0;
    endtask

    // Poll the output off its edges; count edges and the narrowest pulse.
    task automatic observe(input real dur, output int edges, output real minw);
        real t_end, last_t;
        logic prev;
        bit seen;
        edges = 0;
        minw = 1.0e9;
        seen = 0;
        last_t = 0.0;
        #0.05;
        prev = sd_clk;
        t_end = $realtime + dur;
        while ($realtime < t_end) begin
            #0.1;
            if (sd_clk !== prev) begin
                if (seen && ($realtime - last_t) < minw) minw = $realtime - last_t;
                seen = 1;
                last_t = $realtime;
                edges++;
                prev = sd_clk;
            end
        end
        @(negedge reg_clk);
    endtask

    task automatic measure(output real hi, output real lo);
        real t0, t1, t2;
        @(posedge sd_clk); t0 = $realtime;
        @(negedge sd_clk); t1 = $realtime;
        @(posedge sd_clk); t2 = $realtime;
        hi = t1 - t0;
        lo = t2 - t1;
        @(negedge reg_clk);
    endtask

    task automatic run_and_check(input string req, input bit sel, input int code, input int rev);
        real hi, lo, e;
        rev_id = 8'(rev);
        write_cfg(1'b1, sel, code, 1'b1);
        #400;
        @(negedge reg_clk);
        measure(hi, lo);
        e = exp_half(sel, code, rev);
        check_real({req, " high time"}, hi, e);
        check_real({req, " low time"}, lo, e);
    endtask

    initial begin
        #700000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int edges;
        real minw, hi, lo;
        void'($urandom(32'd1234));
        repeat (20) @(negedge reg_clk);
        rst_n = 1'b1;
        @(negedge reg_clk);

        // R1: reset state, output low and quiet
        observe(200.0, edges, minw);
        check_int("R1 edges after reset", edges, 0);
        check_int("R1 level after reset", int'(sd_clk), 0);

        // R9: data without strobe has no effect
        write_cfg(1'b1, 1'b0, 0, 1'b0);
        observe(200.0, edges, minw);
        check_int("R9 no strobe no edges", edges, 0);

        // R1/R3: only enable set -> bus clock divided by 2
        rev_id = 8'd0;
        write_cfg(1'b1, 1'b0, 0, 1'b1);
        #200;
        @(negedge reg_clk);
        measure(hi, lo);
        check_real("R1 R3 default /2 high", hi, 5.0);
        check_real("R9 R3 default /2 low", lo, 5.0);

        // R3: every even code on the bus clock
        for (int c = 0; c < 7; c++) run_and_check("R3 code", 1'b0, c, 0);
        // R4: code 7 on early revisions, including the boundary value 1
        run_and_check("R4 rev0 /16", 1'b0, 7, 0);
        run_and_check("R4 rev1 /16 pll", 1'b1, 7, 1);
        // R5: code 7 on later revisions, including boundary 2 and top 255
        run_and_check("R5 rev2 bypass bus", 1'b0, 7, 2);
        run_and_check("R5 rev255 bypass pll", 1'b1, 7, 255);
        // R6: PLL selection
        run_and_check("R6 pll code2", 1'b1, 2, 0);
        run_and_check("R6 bus code2", 1'b0, 2, 0);

        // Random mix of source, code and revision
        for (int i = 0; i < 14; i++) begin
            int c, r;
            bit s;
            c = int'($urandom_range(0, 7));
            r = int'($urandom_range(0, 4));
            s = 1'($urandom_range(0, 1));
            run_and_check("R3 R4 R5 R6 random", s, c, r);
        end

        // R7: source switches in /2 mode, no pulse below 5 ns
        rev_id = 8'd0;
        write_cfg(1'b1, 1'b0, 0, 1'b1);
        #200;
        @(negedge reg_clk);
        for (int k = 0; k < 4; k++) begin
            write_cfg(1'b1, 1'(k % 2 == 0), 0, 1'b1);
            observe(300.0, edges, minw);
            check_min("R7 switch /2", minw, 5.0);
        end
        // R7: source switches in bypass, no pulse below the bus half period
        rev_id = 8'd3;
        for (int k = 0; k < 4; k++) begin
            write_cfg(1'b1, 1'(k % 2 == 0), 7, 1'b1);
            observe(300.0, edges, minw);
            check_min("R7 switch bypass", minw, 2.5);
        end

        // R8: slow ratio to fast ratio and back on the bus clock
        rev_id = 8'd0;
        write_cfg(1'b1, 1'b0, 6, 1'b1);
        #300;
        @(negedge reg_clk);
        write_cfg(1'b1, 1'b0, 0, 1'b1);
        observe(300.0, edges, minw);
        check_min("R8 code 6->0", minw, 5.0);
        write_cfg(1'b1, 1'b0, 3, 1'b1);
        observe(300.0, edges, minw);
        check_min("R8 code 0->3", minw, 5.0);
        measure(hi, lo);
        check_real("R8 new ratio high", hi, 20.0);
        // R8: divided to bypass and back
        rev_id = 8'd2;
        write_cfg(1'b1, 1'b0, 7, 1'b1);
        observe(300.0, edges, minw);
        check_min("R8 to bypass", minw, 2.5);
        write_cfg(1'b1, 1'b0, 1, 1'b1);
        observe(300.0, edges, minw);
        check_min("R8 from bypass", minw, 2.5);

        // R2: gate off from divided mode, then quiet and low
        write_cfg(1'b1, 1'b1, 2, 1'b1);
        #300;
        @(negedge reg_clk);
        write_cfg(1'b0, 1'b1, 2, 1'b1);
        observe(300.0, edges, minw);
        check_min("R2 gate off no runt", minw, 21.0);
        observe(300.0, edges, minw);
        check_int("R2 gated edges", edges, 0);
        check_int("R2 gated level", int'(sd_clk), 0);
        // R2: gate off from bypass
        write_cfg(1'b1, 1'b0, 7, 1'b1);
        #300;
        @(negedge reg_clk);
        write_cfg(1'b0, 1'b0, 7, 1'b1);
        observe(300.0, edges, minw);
        check_min("R2 gate off bypass no runt", minw, 2.5);
        observe(300.0, edges, minw);
        check_int("R2 gated bypass edges", edges, 0);
        // R2: gate back on gives the full ratio
        run_and_check("R2 regate", 1'b0, 4, 2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule